// File: doc/BRIEF.md
# Interrupt vector-entry P/Q state engine

This block turns a trigger for one interrupt source into at most one memory read, at most one byte write and at most one interrupt request. On a trigger it computes where the source's entry sits in an in-memory vector table and reads the 64-bit entry. It then decodes the target server, the priority, a generation bit and two coalescing flags. P marks an interrupt that has been sent and is waiting for service. Q marks a trigger that arrived while the source was busy or masked. From the flags it picks one action: send the interrupt and set P, record the trigger by setting Q, or drop it. The flag update is a single byte written back into the entry. When the action is a send, the interrupt goes out to a presenter after the write has been accepted.

Configuration comes in on plain inputs: table enable, base address, length, entry size and interrupt number offset. The engine serves one trigger at a time. The trigger, read-request, write and interrupt ports use valid/ready. A valid, once raised, stays up with its payload stable until ready is seen high at a rising clock edge. The engine lowers `trig_ready` while it works on a trigger. The read response has no ready and is taken only while a read is outstanding. The fabric, the memory and the presenter are outside the block.

Top module: `msi_pq_engine`

## Requirements
- R1: The entry address is `cfg_tbl_base + src*128` when `cfg_big_entry` is 1, otherwise `cfg_tbl_base + src*16`. One read request carries this address.
- R2: When `cfg_tbl_en` is 0, or the source number is not below `cfg_tbl_len`, the trigger is accepted and discarded. No read, write or interrupt follows.
- R3: When P=0 and Q=0 and the priority is 0xFF, the source is masked. The only effect is a write of 0x01 at entry address + 5, and no interrupt is sent.
- R4: When P=0 and Q=0 and the priority is not 0xFF, the P byte is written first. Once that write is accepted, an interrupt is raised with the decoded server and priority.
- R5: When P=1 and Q=0, the only effect is a write of 0x01 at entry address + 5.
- R6: When Q=1, the trigger is dropped with no write and no interrupt, whatever the value of P.
- R7: The P byte is written at entry address + 4 with value `{6'b0, gen, 1'b1}`. The Q byte is always 0x01 at entry address + 5.
- R8: `irq_server` is the 16-bit server field shifted right by two, which drops its two low link bits.
- R9: With `trig_force` set, the stored P and Q bits are ignored and the engine acts as if both were 0.
- R10: `irq_num` is the source number plus `cfg_irq_offset`, modulo 2^IRQ_W.
- R11: Memory byte k of the entry travels on read-data lane k (bits 8k+7..8k), and the entry is a big-endian value with byte 0 most significant. In that value the server is bits 63:48, the priority 47:40, P is bit 24, the generation is bit 25 and Q is bit 16.
- R12: A read response with `rd_rsp_err` set ends the trigger with no write and no interrupt.
- R13: `trig_ready` is 1 only while idle. Trigger inputs presented during a busy period are ignored. Each valid holds with a stable payload until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tbl_en | input | 1 | Vector table enable |
| cfg_big_entry | input | 1 | 1: 128-byte entries, 0: 16-byte entries |
| cfg_tbl_base | input | ADDR_W | Table base address |
| cfg_tbl_len | input | SRC_W+1 | Number of valid sources |
| cfg_irq_offset | input | IRQ_W | Added to source number for the interrupt number |
| trig_valid | input | 1 | Trigger request |
| trig_ready | output | 1 | Engine idle and accepting a trigger |
| trig_src | input | SRC_W | Source number of the trigger |
| trig_force | input | 1 | Ignore stored P/Q for this trigger |
| rd_req_valid | output | 1 | Entry read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Entry byte address |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_data | input | 64 | Entry bytes, byte k on lane k |
| rd_rsp_err | input | 1 | Read failed |
| wr_valid | output | 1 | Byte write request |
| wr_ready | input | 1 | Byte write accepted |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_byte | output | 8 | Byte value written |
| irq_valid | output | 1 | Interrupt to the presenter |
| irq_ready | input | 1 | Presenter accepts the interrupt |
| irq_server | output | 14 | Target server |
| irq_prio | output | 8 | Interrupt priority |
| irq_num | output | IRQ_W | Interrupt number |

## Verification
The bench sweeps every source number of a 6-bit configuration through all four P/Q states, masked and unmasked priorities, and forced and unforced triggers, with and without back-pressure. It then walks the length boundary in large-entry mode. A design that swapped the mask and pending branches would send where it should only set Q. One that wrote Q when Q was already set would change memory that must stay untouched. Getting the byte swap or the server shift wrong would send the interrupt to a scrambled server. Other cases are a disabled table, a zero length, read errors, and trigger noise while busy. A design that issued a read on an out-of-range source, wrote after a failed read, or latched a second trigger mid-operation would show an extra transfer or a wrong address.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;

  localparam int ENT_W      = 64;
  localparam int SRV_RAW_HI = 63;
  localparam int SRV_RAW_LO = 48;
  localparam int PRIO_HI    = 47;
  localparam int PRIO_LO    = 40;
  localparam int GEN_BIT    = 25;
  localparam int P_BIT      = 24;
  localparam int Q_BIT      = 16;
  localparam int SRV_OUT_W  = (SRV_RAW_HI - SRV_RAW_LO + 1) - 2;
  localparam int PRIO_W     = PRIO_HI - PRIO_LO + 1;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WRITE,
    ST_IRQ
  } eng_state_e;

  typedef enum logic [1:0] {
    ACT_DROP,
    ACT_SET_Q,
    ACT_SEND
  } pq_act_e;

  typedef struct packed {
    logic [SRV_OUT_W-1:0] server;
    logic [PRIO_W-1:0]    prio;
    logic                 gen;
    logic                 p;
    logic                 q;
  } vec_fields_t;

endpackage

// File: rtl/msi_ive_locator.sv
module msi_ive_locator #(
  parameter int SRC_W  = 6,
  parameter int ADDR_W = 32
) (
  input  logic              tbl_en,
  input  logic              big_entry,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [SRC_W:0]    tbl_len,
  input  logic [SRC_W-1:0]  src,
  output logic              src_ok,
  output logic [ADDR_W-1:0] ent_addr
);

  localparam int SHIFT_BIG   = 7;
  localparam int SHIFT_SMALL = 4;

  logic [ADDR_W-1:0] src_wide;

  assign src_wide = ADDR_W'(src);
  assign src_ok   = tbl_en && ({1'b0, src} < tbl_len);
  assign ent_addr = tbl_base + (big_entry ? (src_wide << SHIFT_BIG)
                                          : (src_wide << SHIFT_SMALL));

endmodule

// File: rtl/msi_ive_decode.sv
module msi_ive_decode
  import msi_pq_pkg::*;
(
  input  logic [ENT_W-1:0] bus_data,
  output vec_fields_t      fields
);

  logic [ENT_W-1:0] ent_val;

  for (genvar k = 0; k < ENT_W/8; k++) begin : g_swap
    assign ent_val[ENT_W-1-8*k -: 8] = bus_data[8*k +: 8];
  end

  logic [SRV_RAW_HI-SRV_RAW_LO:0] srv_raw;
  assign srv_raw = ent_val[SRV_RAW_HI:SRV_RAW_LO];

  always_comb begin
    fields.server = srv_raw[SRV_RAW_HI-SRV_RAW_LO:2];
    fields.prio   = ent_val[PRIO_HI:PRIO_LO];
    fields.gen    = ent_val[GEN_BIT];
    fields.p      = ent_val[P_BIT];
    fields.q      = ent_val[Q_BIT];
  end

endmodule

// File: rtl/msi_pq_policy.sv
module msi_pq_policy
  import msi_pq_pkg::*;
(
  input  logic              p,
  input  logic              q,
  input  logic              force_pq,
  input  logic [PRIO_W-1:0] prio,
  output pq_act_e           act
);

  logic [1:0] pq_eff;

  assign pq_eff = force_pq ? 2'b00 : {p, q};

  always_comb begin
    unique case (pq_eff)
      2'b00:   act = (prio == PRIO_MASKED) ? ACT_SET_Q : ACT_SEND;
      2'b10:   act = ACT_SET_Q;
      default: act = ACT_DROP;
    endcase
  end

  always_comb begin
    if (!force_pq && q) begin
      AST_Q_DROPS: assert (act == ACT_DROP); // R6
    end
    if (force_pq && prio != PRIO_MASKED) begin
      AST_FORCE_SENDS: assert (act == ACT_SEND); // R9
    end
    if ((force_pq || (!p && !q)) && prio == PRIO_MASKED) begin
      AST_MASK_NO_SEND: assert (act == ACT_SET_Q); // R3
    end
  end

endmodule

// File: rtl/msi_pq_engine.sv
module msi_pq_engine
  import msi_pq_pkg::*;
#(
  parameter int SRC_W  = 6,
  parameter int ADDR_W = 32,
  parameter int IRQ_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_tbl_en,
  input  logic                 cfg_big_entry,
  input  logic [ADDR_W-1:0]    cfg_tbl_base,
  input  logic [SRC_W:0]       cfg_tbl_len,
  input  logic [IRQ_W-1:0]     cfg_irq_offset,
  input  logic                 trig_valid,
  output logic                 trig_ready,
  input  logic [SRC_W-1:0]     trig_src,
  input  logic                 trig_force,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [ADDR_W-1:0]    rd_req_addr,
  input  logic                 rd_rsp_valid,
  input  logic [ENT_W-1:0]     rd_rsp_data,
  input  logic                 rd_rsp_err,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [7:0]           wr_byte,
  output logic                 irq_valid,
  input  logic                 irq_ready,
  output logic [SRV_OUT_W-1:0] irq_server,
  output logic [PRIO_W-1:0]    irq_prio,
  output logic [IRQ_W-1:0]     irq_num
);

  localparam logic [ADDR_W-1:0] P_BYTE_OFS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] Q_BYTE_OFS = ADDR_W'(5);
  localparam logic [7:0]        Q_BYTE_VAL = 8'h01;

  eng_state_e          state_q;
  logic [SRC_W-1:0]    src_q;
  logic                force_q;
  logic [ADDR_W-1:0]   addr_q;
  pq_act_e             act_q;
  logic [SRV_OUT_W-1:0] server_q;
  logic [PRIO_W-1:0]   prio_q;
  logic                gen_q;

  logic                src_ok;
  logic [ADDR_W-1:0]   ent_addr;
  vec_fields_t         fields;
  pq_act_e             act_d;

  msi_ive_locator #(
    .SRC_W  (SRC_W),
    .ADDR_W (ADDR_W)
  ) u_locator (
    .tbl_en    (cfg_tbl_en),
    .big_entry (cfg_big_entry),
    .tbl_base  (cfg_tbl_base),
    .tbl_len   (cfg_tbl_len),
    .src       (trig_src),
    .src_ok    (src_ok),
    .ent_addr  (ent_addr)
  );

  msi_ive_decode u_decode (
    .bus_data (rd_rsp_data),
    .fields   (fields)
  );

  msi_pq_policy u_policy (
    .p        (fields.p),
    .q        (fields.q),
    .force_pq (force_q),
    .prio     (fields.prio),
    .act      (act_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      src_q    <= '0;
      force_q  <= 1'b0;
      addr_q   <= '0;
      act_q    <= ACT_DROP;
      server_q <= '0;
      prio_q   <= '0;
      gen_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trig_valid) begin
            src_q   <= trig_src;
            force_q <= trig_force;
            addr_q  <= ent_addr;
            if (src_ok) begin
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          if (rd_req_ready) begin
            state_q <= ST_RD_WAIT;
          end
        end
        ST_RD_WAIT: begin
          if (rd_rsp_valid) begin
            server_q <= fields.server;
            prio_q   <= fields.prio;
            gen_q    <= fields.gen;
            act_q    <= act_d;
            if (rd_rsp_err || act_d == ACT_DROP) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            state_q <= (act_q == ACT_SEND) ? ST_IRQ : ST_IDLE;
          end
        end
        ST_IRQ: begin
          if (irq_ready) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign trig_ready   = (state_q == ST_IDLE);
  assign rd_req_valid = (state_q == ST_RD_REQ);
  assign rd_req_addr  = addr_q;
  assign wr_valid     = (state_q == ST_WRITE);
  assign wr_addr      = addr_q + ((act_q == ACT_SEND) ? P_BYTE_OFS : Q_BYTE_OFS);
  assign wr_byte      = (act_q == ACT_SEND) ? {6'b0, gen_q, 1'b1} : Q_BYTE_VAL;
  assign irq_valid    = (state_q == ST_IRQ);
  assign irq_server   = server_q;
  assign irq_prio     = prio_q;
  assign irq_num      = IRQ_W'(src_q) + cfg_irq_offset;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R1

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_byte)); // R13

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_server) && $stable(irq_prio)); // R13

  AST_IRQ_AFTER_P: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(wr_valid && wr_ready)); // R4

  AST_OOR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_ready && !src_ok |=> trig_ready && !rd_req_valid); // R2

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && rd_rsp_err && !trig_ready && !rd_req_valid && !wr_valid && !irq_valid
    |=> !wr_valid && !irq_valid); // R12

  AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trig_ready, rd_req_valid, wr_valid, irq_valid})); // R13

endmodule

// File: tb/test_msi_pq_engine.sv
module test_msi_pq_engine;

  localparam int SRC_W  = 6;
  localparam int ADDR_W = 32;
  localparam int IRQ_W  = 16;
  localparam int NSRC   = 1 << SRC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              cfg_tbl_en;
  logic              cfg_big_entry;
  logic [ADDR_W-1:0] cfg_tbl_base;
  logic [SRC_W:0]    cfg_tbl_len;
  logic [IRQ_W-1:0]  cfg_irq_offset;
  logic              trig_valid;
  logic              trig_ready;
  logic [SRC_W-1:0]  trig_src;
  logic              trig_force;
  logic              rd_req_valid;
  logic              rd_req_ready;
  logic [ADDR_W-1:0] rd_req_addr;
  logic              rd_rsp_valid;
  logic [63:0]       rd_rsp_data;
  logic              rd_rsp_err;
  logic              wr_valid;
  logic              wr_ready;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_byte;
  logic              irq_valid;
  logic              irq_ready;
  logic [13:0]       irq_server;
  logic [7:0]        irq_prio;
  logic [IRQ_W-1:0]  irq_num;

  msi_pq_engine #(.SRC_W(SRC_W), .ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) i_msi_pq_engine (
    .clk(clk), .rst_n(rst_n),
    .cfg_tbl_en(cfg_tbl_en), .cfg_big_entry(cfg_big_entry), .cfg_tbl_base(cfg_tbl_base),
    .cfg_tbl_len(cfg_tbl_len), .cfg_irq_offset(cfg_irq_offset),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_src(trig_src), .trig_force(trig_force),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_server(irq_server),
    .irq_prio(irq_prio), .irq_num(irq_num)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] ent [NSRC];
  bit err_mode = 0;

  int          n_rd, n_wr, n_irq;
  logic [31:0] o_rd_addr, o_wr_addr;
  logic [7:0]  o_wr_byte;
  logic [13:0] o_srv;
  logic [7:0]  o_prio;
  logic [15:0] o_num;
  bit          hung;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] to_bus(input logic [63:0] v);
    logic [63:0] b;
    for (int k = 0; k < 8; k++) b[8*k +: 8] = v[63-8*k -: 8];
    return b;
  endfunction

  function automatic logic [63:0] mk_ent(input logic [15:0] srv, input logic [7:0] prio,
                                         input bit gen, input bit p, input bit q);
    return {srv, prio, 8'h00, 6'b0, gen, p, 7'b0, q, 16'h0000};
  endfunction

  task automatic run_trig(input int src, input bit frc, input bit bp, input bit noise);
    bit pend = 0;
    logic [31:0] ea;
    n_rd = 0; n_wr = 0; n_irq = 0; hung = 1;
    ea = cfg_tbl_base + src * (cfg_big_entry ? 128 : 16);
    @(negedge clk);
    trig_valid = 1; trig_src = SRC_W'(src); trig_force = frc;
    @(negedge clk);
    trig_valid = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      rd_rsp_valid = 0; rd_rsp_err = 0;
      if (pend) begin
        rd_rsp_valid = 1;
        rd_rsp_data  = to_bus(ent[src]);
        rd_rsp_err   = err_mode;
        pend = 0;
      end
      rd_req_ready = bp ? cyc[0] : 1'b1;
      wr_ready     = bp ? cyc[1] : 1'b1;
      irq_ready    = bp ? ~cyc[0] : 1'b1;
      if (noise) begin
        trig_valid = 1; trig_src = SRC_W'(src ^ 1); trig_force = ~frc;
      end
      #1;
      if (trig_ready) begin
        trig_valid = 0;
        hung = 0;
        break;
      end
      if (rd_req_valid && rd_req_ready) begin
        n_rd++; o_rd_addr = rd_req_addr; pend = 1;
      end
      if (wr_valid && wr_ready) begin
        n_wr++; o_wr_addr = wr_addr; o_wr_byte = wr_byte;
        if (wr_addr >= ea && wr_addr < ea + 8)
          ent[src][63 - 8*(wr_addr - ea) -: 8] = wr_byte;
      end
      if (irq_valid && irq_ready) begin
        n_irq++; o_srv = irq_server; o_prio = irq_prio; o_num = irq_num;
      end
      @(negedge clk);
    end
    trig_valid = 0; rd_rsp_valid = 0; rd_rsp_err = 0;
    chk(!hung, "R13", "engine back to ready", hung, 0);
  endtask

  // Runs one trigger and checks it against the requirement model.
  task automatic trial(input int src, input bit frc, input bit bp, input bit noise);
    logic [63:0] orig;
    logic [31:0] ea;
    bit in_rng, p, q, gen;
    logic [7:0] prio;
    logic [1:0] pq;
    string tag;
    orig = ent[src];
    ea = cfg_tbl_base + src * (cfg_big_entry ? 128 : 16);
    in_rng = cfg_tbl_en && (src < cfg_tbl_len);
    run_trig(src, frc, bp, noise);
    if (!in_rng) begin
      chk(n_rd == 0 && n_wr == 0 && n_irq == 0, "R2", "transfers on discarded trigger",
          n_rd + n_wr + n_irq, 0);
      return;
    end
    chk(n_rd == 1, "R1", "read count", n_rd, 1);
    chk(o_rd_addr == ea, "R1", "entry address", o_rd_addr, ea);
    if (err_mode) begin
      chk(n_wr == 0 && n_irq == 0, "R12", "activity after read error", n_wr + n_irq, 0);
      return;
    end
    prio = orig[47:40]; gen = orig[25]; p = orig[24]; q = orig[16];
    pq = frc ? 2'b00 : {p, q};
    if (pq == 2'b00 && prio != 8'hFF) begin
      tag = frc ? "R9" : "R4";
      chk(n_wr == 1 && n_irq == 1, tag, "send write+irq counts", {n_wr, n_irq}, {32'd1, 32'd1});
      chk(o_wr_addr == ea + 4 && o_wr_byte == {6'b0, gen, 1'b1}, "R7", "P byte addr/value",
          {o_wr_addr, o_wr_byte}, {ea + 32'd4, 6'b0, gen, 1'b1});
      chk(o_srv == orig[63:50] && o_prio == prio, "R8", "server/priority (R11 layout)",
          {o_srv, o_prio}, {orig[63:50], prio});
      chk(o_num == 16'(src + cfg_irq_offset), "R10", "interrupt number", o_num,
          16'(src + cfg_irq_offset));
    end else if (pq == 2'b11 || pq == 2'b01) begin
      chk(n_wr == 0 && n_irq == 0, "R6", "drop with Q set", {n_wr, n_irq}, 0);
      chk(ent[src] == orig, "R6", "entry unchanged", ent[src], orig);
    end else begin
      tag = (pq == 2'b10) ? "R5" : (frc ? "R9" : "R3");
      chk(n_wr == 1 && n_irq == 0, tag, "Q-only counts", {n_wr, n_irq}, {32'd1, 32'd0});
      chk(o_wr_addr == ea + 5 && o_wr_byte == 8'h01, "R7", "Q byte addr/value",
          {o_wr_addr, o_wr_byte}, {ea + 32'd5, 8'h01});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R13 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cfg_tbl_en = 1; cfg_big_entry = 0; cfg_tbl_base = 32'h0000_1000;
    cfg_tbl_len = 7'd64; cfg_irq_offset = 16'h0200;
    trig_valid = 0; trig_src = 0; trig_force = 0;
    rd_req_ready = 1; rd_rsp_valid = 0; rd_rsp_data = 0; rd_rsp_err = 0;
    wr_ready = 1; irq_ready = 1;
    for (int i = 0; i < NSRC; i++) ent[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(trig_ready && !rd_req_valid && !wr_valid && !irq_valid, "R13", "reset state",
        {trig_ready, rd_req_valid, wr_valid, irq_valid}, 4'b1000);

    // Small entries: every source, every P/Q, masked or not, forced or not (R3 R4 R5 R6 R9 R11).
    for (int s = 0; s < NSRC; s++)
      for (int pqs = 0; pqs < 4; pqs++)
        for (int m = 0; m < 2; m++)
          for (int f = 0; f < 2; f++) begin
            ent[s] = mk_ent(16'h1234 + 16'(s * 16'h0101) + 16'(pqs),
                            m ? 8'hFF : 8'((s * 3 + pqs) & 8'h7F),
                            s[0] ^ f[0], pqs[1], pqs[0]);
            trial(s, f[0], s[1], s[2] & m[0]);
          end

    // Large entries and the length boundary (R1 R2 R10).
    cfg_big_entry = 1; cfg_tbl_base = 32'h0004_0000; cfg_tbl_len = 7'd40; cfg_irq_offset = 16'hFFF0;
    for (int s = 0; s < NSRC; s++) begin
      ent[s] = mk_ent(16'hBEEF ^ 16'(s), 8'(s + 1), s[1], 0, 0);
      trial(s, 0, s[0], 0);
    end

    // Table disabled and zero length (R2).
    cfg_tbl_en = 0; cfg_tbl_len = 7'd64;
    for (int s = 0; s < 8; s++) begin
      ent[s] = mk_ent(16'h0004, 8'h10, 0, 0, 0);
      trial(s, 0, 0, 0);
    end
    cfg_tbl_en = 1; cfg_tbl_len = 7'd0;
    trial(0, 1, 0, 0);

    // Read errors leave everything untouched (R12).
    cfg_tbl_len = 7'd64; err_mode = 1;
    for (int s = 0; s < 8; s++) begin
      ent[s] = mk_ent(16'h0ABC, 8'h05, 1, 0, 0);
      trial(s, s[0], s[1], 0);
    end
    err_mode = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule